// File: doc/BRIEF.md
# Colour Table Grayscale Converter

This block turns a run of entries in a colour lookup table into shades of grey, in place. A caller gives it a first entry index and an entry count, then pulses `start`. The converter walks the entries upward from the first index. For each entry it reads the three colour components from the table, one per cycle. It forms a rounded, weighted brightness value and clamps it to six bits. It then writes that value into the red, green and blue components of the same entry.

The table sits outside the block. The converter drives a read port and a write port that name one entry and one component at a time. Read data comes back one cycle after the request. While a run is in progress the block reports `busy`. When the run ends it raises `done` for one cycle, and after that it takes a new request.

Top module: `clut_gray_conv`

## Requirements
- R1: The grey value is (77*R + 151*G + 28*B + 128) >> 8, computed on the raw component values. With R=2, G=0, B=0 the result is 1, and with R=1, G=0, B=0 it is 0.
- R2: A grey value above 63 is written as 63. Every value written is at most 63.
- R3: For each entry, three writes happen on consecutive cycles, in the component order red (code 0), green (code 1), blue (code 2). All three carry the same index and the same grey value.
- R4: A requested count above 256 is treated as 256, so each table entry is converted exactly once.
- R5: Entries are handled in ascending index order. Each entry is read on three consecutive cycles as red (code 0), green (code 1), blue (code 2), and all of its reads come before its writes. `rd_data` is taken as valid one cycle after the read request.
- R6: Entry indices wrap from 255 to 0 when the range runs past the end of the table.
- R7: A count of 0 makes no table access, and `done` is high in the cycle after the start is accepted.
- R8: `done` is a single-cycle pulse that follows the last write of the run. `busy` is high from the accepted start through the `done` cycle and low after it.
- R9: A `start` pulse while `busy` is high is ignored. It adds no reads and no writes.
- R10: The weighted sum cannot overflow. An entry of 255, 255, 255 gives the clamped value 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a run (taken only when idle) |
| start_idx | input | IDX_W | First entry index |
| count | input | CNT_IN_W | Number of entries requested |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_en | output | 1 | Table read request |
| rd_idx | output | IDX_W | Entry index of the read |
| rd_comp | output | 2 | Component of the read: 0 red, 1 green, 2 blue |
| rd_data | input | COMP_W | Component value, valid one cycle after rd_en |
| wr_en | output | 1 | Table write request |
| wr_idx | output | IDX_W | Entry index of the write |
| wr_comp | output | 2 | Component of the write: 0 red, 1 green, 2 blue |
| wr_data | output | COMP_W | Grey value to write |

## Verification
The first run covers hand-picked entries. A saturated white entry separates the clamp from an overflowing sum. Small red-only values show whether the +128 rounding term is present, and a mid-grey entry sits just under the clamp limit. A run that crosses the top of the table separates index wrapping from running off the end. Count values of 0, 1 and 300 test the empty case, the single-entry case and the 256 limit. A start pulse given in the middle of a run shows whether the busy interlock holds.

// File: rtl/clut_gray_pkg.sv
package clut_gray_pkg;
  localparam logic [1:0] COMP_RED   = 2'd0;
  localparam logic [1:0] COMP_GREEN = 2'd1;
  localparam logic [1:0] COMP_BLUE  = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_R, ST_RD_G, ST_RD_B, ST_CAP,
    ST_WR_R, ST_WR_G, ST_WR_B, ST_DONE
  } conv_state_t;
endpackage

// File: rtl/clut_range_ctl.sv
module clut_range_ctl #(
  parameter int IDX_W    = 8,
  parameter int CNT_IN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [IDX_W-1:0]    start_idx,
  input  logic [CNT_IN_W-1:0] count,
  output logic [IDX_W-1:0]    cur_idx,
  output logic                req_empty,
  output logic                last_entry
);
  localparam int TBL_N = 1 << IDX_W;
  localparam int REM_W = IDX_W + 1;

  logic [REM_W-1:0] clamped;
  logic [REM_W-1:0] remain;

  always_comb begin
    if (count > CNT_IN_W'(TBL_N)) clamped = REM_W'(TBL_N);
    else                          clamped = count[REM_W-1:0];
  end

  assign req_empty  = (clamped == '0);
  assign last_entry = (remain == REM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      remain  <= '0;
    end else if (load) begin
      cur_idx <= start_idx;
      remain  <= clamped;
    end else if (step) begin
      cur_idx <= cur_idx + 1'b1;
      remain  <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/clut_luma_unit.sv
module clut_luma_unit #(
  parameter int COMP_W   = 8,
  parameter int LUMA_MAX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_r,
  input  logic              cap_g,
  input  logic              cap_b,
  input  logic [COMP_W-1:0] rd_data,
  output logic [COMP_W-1:0] luma
);
  localparam int ACC_W = COMP_W + 9;

  logic [COMP_W-1:0] r_q, g_q, b_q;

  function automatic logic [COMP_W-1:0] weigh(input logic [COMP_W-1:0] r,
                                              input logic [COMP_W-1:0] g,
                                              input logic [COMP_W-1:0] b);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] y;
    acc = ACC_W'(r) * ACC_W'(77) + ACC_W'(g) * ACC_W'(151)
        + ACC_W'(b) * ACC_W'(28) + ACC_W'(128);
    y = acc >> 8;
    if (y > ACC_W'(LUMA_MAX)) return COMP_W'(LUMA_MAX);
    return y[COMP_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      g_q <= '0;
      b_q <= '0;
    end else begin
      if (cap_r) r_q <= rd_data;
      if (cap_g) g_q <= rd_data;
      if (cap_b) b_q <= rd_data;
    end
  end

  assign luma = weigh(r_q, g_q, b_q);
endmodule

// File: rtl/clut_seq_fsm.sv
module clut_seq_fsm
  import clut_gray_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       req_empty,
  input  logic       last_entry,
  output logic       load,
  output logic       step,
  output logic       cap_r,
  output logic       cap_g,
  output logic       cap_b,
  output logic       rd_en,
  output logic [1:0] rd_comp,
  output logic       wr_en,
  output logic [1:0] wr_comp,
  output logic       busy,
  output logic       done
);
  conv_state_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    load  = 1'b0;
    step  = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        load  = 1'b1;
        st_nx = req_empty ? ST_DONE : ST_RD_R;
      end
      ST_RD_R: st_nx = ST_RD_G;
      ST_RD_G: st_nx = ST_RD_B;
      ST_RD_B: st_nx = ST_CAP;
      ST_CAP:  st_nx = ST_WR_R;
      ST_WR_R: st_nx = ST_WR_G;
      ST_WR_G: st_nx = ST_WR_B;
      ST_WR_B: begin
        step  = 1'b1;
        st_nx = last_entry ? ST_DONE : ST_RD_R;
      end
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign rd_en   = (st == ST_RD_R) || (st == ST_RD_G) || (st == ST_RD_B);
  assign rd_comp = (st == ST_RD_G) ? COMP_GREEN : (st == ST_RD_B) ? COMP_BLUE : COMP_RED;
  assign wr_en   = (st == ST_WR_R) || (st == ST_WR_G) || (st == ST_WR_B);
  assign wr_comp = (st == ST_WR_G) ? COMP_GREEN : (st == ST_WR_B) ? COMP_BLUE : COMP_RED;
  assign cap_r   = (st == ST_RD_G);
  assign cap_g   = (st == ST_RD_B);
  assign cap_b   = (st == ST_CAP);
  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_DONE);
endmodule

// File: rtl/clut_gray_conv.sv
module clut_gray_conv #(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int CNT_IN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IDX_W-1:0]    start_idx,
  input  logic [CNT_IN_W-1:0] count,
  output logic                busy,
  output logic                done,
  output logic                rd_en,
  output logic [IDX_W-1:0]    rd_idx,
  output logic [1:0]          rd_comp,
  input  logic [COMP_W-1:0]   rd_data,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [1:0]          wr_comp,
  output logic [COMP_W-1:0]   wr_data
);
  logic             run_load;
  logic             entry_step;
  logic             cap_r, cap_g, cap_b;
  logic             req_empty, last_entry;
  logic [IDX_W-1:0] cur_idx;

  clut_range_ctl #(.IDX_W(IDX_W), .CNT_IN_W(CNT_IN_W)) u_range (
    .clk(clk), .rst_n(rst_n), .load(run_load), .step(entry_step),
    .start_idx(start_idx), .count(count), .cur_idx(cur_idx),
    .req_empty(req_empty), .last_entry(last_entry)
  );

  clut_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .req_empty(req_empty),
    .last_entry(last_entry), .load(run_load), .step(entry_step),
    .cap_r(cap_r), .cap_g(cap_g), .cap_b(cap_b),
    .rd_en(rd_en), .rd_comp(rd_comp), .wr_en(wr_en), .wr_comp(wr_comp),
    .busy(busy), .done(done)
  );

  clut_luma_unit #(.COMP_W(COMP_W), .LUMA_MAX(63)) u_luma (
    .clk(clk), .rst_n(rst_n), .cap_r(cap_r), .cap_g(cap_g), .cap_b(cap_b),
    .rd_data(rd_data), .luma(wr_data)
  );

  assign rd_idx = cur_idx;
  assign wr_idx = cur_idx;
endmodule

// File: rtl/clut_gray_chk.sv
module clut_gray_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [1:0]        rd_comp,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_comp,
  input logic [COMP_W-1:0] wr_data
);
  logic [IDX_W-1:0] last_red_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        last_red_idx <= '0;
    else if (rd_en && rd_comp == 2'd0) last_red_idx <= rd_idx;
  end

  a_r2_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data <= COMP_W'(63));

  a_r3_green_same: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_comp == 2'd0) |=> (wr_en && wr_comp == 2'd1 && $stable(wr_data) && $stable(wr_idx)));

  a_r3_blue_same: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_comp == 2'd1) |=> (wr_en && wr_comp == 2'd2 && $stable(wr_data) && $stable(wr_idx)));

  a_r3_write_own_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == last_red_idx);

  a_r5_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_comp == 2'd0) |=> (rd_en && rd_comp == 2'd1 && $stable(rd_idx)));

  a_r5_green_then_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_comp == 2'd1) |=> (rd_en && rd_comp == 2'd2 && $stable(rd_idx)));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  a_r6_next_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_comp == 2'd2) |=> (done || (rd_en && rd_comp == 2'd0 && rd_idx == IDX_W'($past(wr_idx) + 1'b1))));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind clut_gray_conv clut_gray_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_comp(rd_comp),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_comp(wr_comp), .wr_data(wr_data)
);

// File: tb/clut_gray_conv_bench.sv
module clut_gray_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  start_idx = '0;
  logic [15:0] count = '0;
  logic        busy, done, rd_en, wr_en;
  logic [7:0]  rd_idx, wr_idx, wr_data;
  logic [7:0]  rd_data = '0;
  logic [1:0]  rd_comp, wr_comp;

  int checks = 0;
  int errors = 0;
  int wr_total = 0;
  string cur_tag = "R5";
  logic [7:0] tbl [3][256];
  int rd_q[$];
  int wr_q[$];

  always #2.5 clk = ~clk;

  clut_gray_conv u_clut_gray_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx), .count(count),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_idx(rd_idx), .rd_comp(rd_comp),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_comp(wr_comp), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (rd_en) rd_data <= tbl[rd_comp][rd_idx];
    if (wr_en) tbl[wr_comp][wr_idx] <= wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int grey_of(input int r, input int g, input int b);
    int v;
    v = (r * 77 + g * 151 + b * 28 + 128) / 256;
    return (v < 63) ? v : 63;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        if (rd_q.size() == 0) check(1'b0, {cur_tag, " R9 unexpected read"}, rd_idx * 4 + rd_comp, -1);
        else begin
          int e;
          e = rd_q.pop_front();
          check(rd_idx * 4 + rd_comp == e, {cur_tag, " R5 read order"}, rd_idx * 4 + rd_comp, e);
        end
      end
      if (wr_en) begin
        wr_total++;
        if (wr_q.size() == 0) check(1'b0, {cur_tag, " R9 unexpected write"}, wr_idx, -1);
        else begin
          int e, a;
          e = wr_q.pop_front();
          a = (int'(wr_idx) << 16) | (int'(wr_comp) << 8) | int'(wr_data);
          check(a == e, {cur_tag, " R1 R2 R3 write"}, a, e);
        end
      end
    end
  end

  task automatic run(input int sidx, input int cnt, input string tag, input bit poke);
    int n, cyc;
    n = (cnt > 256) ? 256 : cnt;
    for (int e = 0; e < n; e++) begin
      int i, y;
      i = (sidx + e) % 256;
      y = grey_of(tbl[0][i], tbl[1][i], tbl[2][i]);
      for (int c = 0; c < 3; c++) begin
        rd_q.push_back(i * 4 + c);
        wr_q.push_back((i << 16) | (c << 8) | y);
      end
    end
    cur_tag = tag;
    @(negedge clk);
    start = 1'b1; start_idx = 8'(sidx); count = 16'(cnt);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (poke) begin
      repeat (10) @(negedge clk);
      cyc += 10;
      start = 1'b1; start_idx = 8'd100; count = 16'd5;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    check(rd_q.size() == 0 && wr_q.size() == 0, {tag, " R8 all accesses before done"},
          rd_q.size() + wr_q.size(), 0);
    if (cnt == 0) check(cyc == 1, "R7 done latency for empty run", cyc, 1);
    @(negedge clk);
    check(!done && !busy, {tag, " R8 single done pulse"}, {done, busy}, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      check(!busy, "R9 no second run", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) tbl[c][i] = 8'((i * 37 + c * 91 + 13) & 255);
    tbl[0][0] = 255; tbl[1][0] = 255; tbl[2][0] = 255;
    tbl[0][1] = 2;   tbl[1][1] = 0;   tbl[2][1] = 0;
    tbl[0][2] = 63;  tbl[1][2] = 63;  tbl[2][2] = 63;
    tbl[0][3] = 1;   tbl[1][3] = 0;   tbl[2][3] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R8 reset idle", {busy, done, rd_en, wr_en}, 0);
    rst_n = 1'b1;

    run(0, 4, "R1", 1'b0);
    check(tbl[0][1] == 1, "R1 rounding up", tbl[0][1], 1);
    check(tbl[1][3] == 0, "R1 rounding down", tbl[1][3], 0);
    check(tbl[2][0] == 63, "R10 white clamps", tbl[2][0], 63);
    check(tbl[0][2] == 63, "R2 mid grey at limit", tbl[0][2], 63);

    run(20, 1, "R5", 1'b0);
    run(250, 10, "R6", 1'b0);
    run(0, 0, "R7", 1'b0);
    run(40, 8, "R9", 1'b1);
    wr_total = 0;
    run(7, 300, "R4", 1'b0);
    check(wr_total == 768, "R4 writes for clamped count", wr_total, 768);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule